// File: doc/BRIEF.md
# RV64 Word-Instruction Operand Extender

This block sits between the register read stage and the ALU of a 64-bit integer datapath. It takes the two source register values, a fully extended 64-bit immediate and the ALU result. From these it forms the two ALU operands and the value to be written back to the destination register. It handles full-width instructions and the 32-bit "word" instructions. For word instructions each source operand is cut to its low 32 bits, then filled upward with zeros or with copies of bit 31, as the signed flag selects. A result that did not come from a load is always filled from bit 31.

The second operand is not chosen by a multiplexer. It is the sum of two gated terms: the extended second register value, which memory accesses suppress, and the immediate, which conditional branches suppress. Decoding guarantees that when neither kind of suppression applies, one of the two terms is zero. For loads, the write-back value comes from a separate load-data input and is passed through untouched. Three sign-bit outputs expose bit 31 of the first register, of the second register and of the result, and only during word instructions. All outputs can be registered by one optional pipeline stage, which is present by default.

Top module: `wext_operand_unit`

## Requirements
- R1: The low 32 bits of `arg1` always equal the low 32 bits of `rv1`.
- R2: With `narrow`=0, the upper 32 bits of `arg1` equal the upper 32 bits of `rv1`.
- R3: With `narrow`=1, the upper 32 bits of `arg1` are all ones when `sgn`=1 and `rv1` bit 31 is 1, and all zeros in every other case.
- R4: `arg2` equals (A + B) modulo 2^64. A is `rv2` extended by the rules of R1 to R3, or zero when `is_load` or `is_store` is set. B is `imm`, or zero when `is_beq` or `is_blt` is set.
- R5: With `is_load`=0 and `narrow`=0, `rvd` equals `alu_res`.
- R6: With `is_load`=0 and `narrow`=1, the low 32 bits of `rvd` equal those of `alu_res`, and each of its upper 32 bits equals `alu_res` bit 31, whatever the value of `sgn`.
- R7: With `is_load`=1, `rvd` equals `load_data` unchanged, and `alu_res` has no effect on it.
- R8: `rv1_sign`, `arg2_sign` and `res_sign` equal bit 31 of `rv1`, `rv2` and `alu_res` respectively when `narrow`=1, and are 0 when `narrow`=0.
- R9: With REG_OUT=1 (the default), every output reflects the inputs sampled at the previous rising clock edge, and a synchronous active-high `rst` clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| rv1 | input | 64 | First source register value |
| rv2 | input | 64 | Second source register value |
| imm | input | 64 | Fully extended immediate |
| alu_res | input | 64 | ALU result |
| load_data | input | 64 | Already extended load data |
| narrow | input | 1 | Word (32-bit) instruction |
| sgn | input | 1 | Signed operation |
| is_load | input | 1 | Load instruction |
| is_store | input | 1 | Store instruction |
| is_beq | input | 1 | Equality branch |
| is_blt | input | 1 | Less-than branch |
| arg1 | output | 64 | First ALU operand |
| arg2 | output | 64 | Second ALU operand |
| rvd | output | 64 | Write-back value |
| rv1_sign | output | 1 | Bit 31 of rv1 during word instructions |
| arg2_sign | output | 1 | Bit 31 of rv2 during word instructions |
| res_sign | output | 1 | Bit 31 of alu_res during word instructions |

## Verification
The properties rely on three promises from the decoder. At most one of the load, store, equality-branch and less-than-branch flags is set. A load is never a word instruction. When none of these four flags is set, `rv2` or `imm` is zero. The stimulus builds every flag combination from five exclusive operation classes, never combines the load class with `narrow`, and in the plain class zeroes `rv2` or `imm` alternately. The data values are corner patterns around bit 31 and bit 63.

// File: rtl/wext_pkg.sv
package wext_pkg;

    localparam int unsigned DATA_W = 64;

    // decoded control flags that steer the extender
    typedef struct packed {
        logic narrow;
        logic sgn;
        logic ld;
        logic st;
        logic beq;
        logic blt;
    } ctl_t;

    // bit-31 observations exported during word instructions
    typedef struct packed {
        logic src1;
        logic src2;
        logic res;
    } sign_bits_t;

    function automatic logic mem_access(input ctl_t c);
        return c.ld | c.st;
    endfunction

    function automatic logic cond_branch(input ctl_t c);
        return c.beq | c.blt;
    endfunction

endpackage

// File: rtl/wext_half_fill.sv
module wext_half_fill #(
    parameter int unsigned W = wext_pkg::DATA_W
) (
    input  logic [W-1:0] val_i,
    input  logic         narrow_i,
    input  logic         fill_en_i,
    output logic [W-1:0] val_o,
    output logic         msb_o
);
    localparam int unsigned H = W / 2;

    logic fill_bit;

    always_comb begin
        msb_o    = narrow_i & val_i[H-1];
        fill_bit = msb_o & fill_en_i;
        if (narrow_i) begin
            val_o = {{H{fill_bit}}, val_i[H-1:0]};
        end else begin
            val_o = val_i;
        end
    end
endmodule

// File: rtl/wext_arg2_sum.sv
module wext_arg2_sum #(
    parameter int unsigned W = wext_pkg::DATA_W
) (
    input  logic [W-1:0]    reg_term_i,
    input  logic [W-1:0]    imm_i,
    input  wext_pkg::ctl_t  ctl_i,
    output logic [W-1:0]    sum_o
);
    logic [W-1:0] reg_gated;
    logic [W-1:0] imm_gated;

    always_comb begin
        reg_gated = wext_pkg::mem_access(ctl_i)  ? '0 : reg_term_i;
        imm_gated = wext_pkg::cond_branch(ctl_i) ? '0 : imm_i;
        sum_o     = reg_gated + imm_gated;
    end
endmodule

// File: rtl/wext_operand_unit.sv
module wext_operand_unit #(
    parameter int unsigned XLEN    = wext_pkg::DATA_W,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] rv1,
    input  logic [XLEN-1:0] rv2,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] alu_res,
    input  logic [XLEN-1:0] load_data,
    input  logic            narrow,
    input  logic            sgn,
    input  logic            is_load,
    input  logic            is_store,
    input  logic            is_beq,
    input  logic            is_blt,
    output logic [XLEN-1:0] arg1,
    output logic [XLEN-1:0] arg2,
    output logic [XLEN-1:0] rvd,
    output logic            rv1_sign,
    output logic            arg2_sign,
    output logic            res_sign
);
    import wext_pkg::*;

    localparam int unsigned HALF = XLEN / 2;
    localparam int unsigned NSRC = 3;   // rv1, rv2, result

    ctl_t       ctl;
    sign_bits_t signs_d;

    logic [XLEN-1:0] src_in  [NSRC];
    logic [XLEN-1:0] src_ext [NSRC];
    logic            src_msb [NSRC];
    logic            src_fill[NSRC];

    logic [XLEN-1:0] arg1_d, arg2_d, rvd_d;

    assign ctl = '{narrow: narrow, sgn: sgn, ld: is_load, st: is_store,
                   beq: is_beq, blt: is_blt};

    assign src_in[0]   = rv1;
    assign src_in[1]   = rv2;
    assign src_in[2]   = alu_res;
    assign src_fill[0] = ctl.sgn;
    assign src_fill[1] = ctl.sgn;
    assign src_fill[2] = 1'b1;      // results always sign-fill

    for (genvar g = 0; g < NSRC; g++) begin : g_fill
        wext_half_fill #(.W(XLEN)) u_fill (
            .val_i    (src_in[g]),
            .narrow_i (ctl.narrow),
            .fill_en_i(src_fill[g]),
            .val_o    (src_ext[g]),
            .msb_o    (src_msb[g])
        );
    end

    wext_arg2_sum #(.W(XLEN)) u_arg2 (
        .reg_term_i(src_ext[1]),
        .imm_i     (imm),
        .ctl_i     (ctl),
        .sum_o     (arg2_d)
    );

    always_comb begin
        arg1_d  = src_ext[0];
        rvd_d   = ctl.ld ? load_data : src_ext[2];
        signs_d = '{src1: src_msb[0], src2: src_msb[1], res: src_msb[2]};
    end

    if (REG_OUT) begin : g_reg
        logic [XLEN-1:0] arg1_q, arg2_q, rvd_q;
        sign_bits_t      signs_q;
        logic            prev_live;

        always_ff @(posedge clk) begin
            if (rst) begin
                arg1_q    <= '0;
                arg2_q    <= '0;
                rvd_q     <= '0;
                signs_q   <= '0;
                prev_live <= 1'b0;
            end else begin
                arg1_q    <= arg1_d;
                arg2_q    <= arg2_d;
                rvd_q     <= rvd_d;
                signs_q   <= signs_d;
                prev_live <= 1'b1;
            end
        end

        assign arg1      = arg1_q;
        assign arg2      = arg2_q;
        assign rvd       = rvd_q;
        assign rv1_sign  = signs_q.src1;
        assign arg2_sign = signs_q.src2;
        assign res_sign  = signs_q.res;

        AST_ARG1_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
            prev_live |-> arg1[HALF-1:0] == $past(rv1[HALF-1:0])); // R1
        AST_ARG1_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
            (prev_live && !$past(narrow)) |-> arg1 == $past(rv1)); // R2
        AST_ARG1_UNSIGNED_ZERO: assert property (@(posedge clk) disable iff (rst)
            (prev_live && $past(narrow) && !$past(sgn)) |-> arg1[XLEN-1:HALF] == '0); // R3
        AST_RVD_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
            (prev_live && $past(is_load)) |-> rvd == $past(load_data)); // R7
        AST_RVD_WORD_FILL: assert property (@(posedge clk) disable iff (rst)
            (prev_live && $past(narrow) && !$past(is_load))
            |-> rvd[XLEN-1:HALF] == {HALF{$past(alu_res[HALF-1])}}); // R6
        AST_SIGNS_FULL_ZERO: assert property (@(posedge clk) disable iff (rst)
            (prev_live && !$past(narrow)) |-> !(rv1_sign | arg2_sign | res_sign)); // R8
        AST_RESET_CLEARS: assert property (@(posedge clk)
            $past(rst) |-> (arg1 == '0 && arg2 == '0 && rvd == '0)); // R9
    end else begin : g_comb
        assign arg1      = arg1_d;
        assign arg2      = arg2_d;
        assign rvd       = rvd_d;
        assign rv1_sign  = signs_d.src1;
        assign arg2_sign = signs_d.src2;
        assign res_sign  = signs_d.res;
    end
endmodule

// File: tb/test_wext_operand_unit.sv
module test_wext_operand_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] rv1 = '0, rv2 = '0, imm = '0, alu_res = '0, load_data = '0;
    logic        narrow = 0, sgn = 0, is_load = 0, is_store = 0, is_beq = 0, is_blt = 0;
    logic [63:0] arg1, arg2, rvd;
    logic        rv1_sign, arg2_sign, res_sign;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wext_operand_unit i_wext_operand_unit (
        .clk(clk), .rst(rst), .rv1(rv1), .rv2(rv2), .imm(imm),
        .alu_res(alu_res), .load_data(load_data), .narrow(narrow), .sgn(sgn),
        .is_load(is_load), .is_store(is_store), .is_beq(is_beq), .is_blt(is_blt),
        .arg1(arg1), .arg2(arg2), .rvd(rvd),
        .rv1_sign(rv1_sign), .arg2_sign(arg2_sign), .res_sign(res_sign)
    );

    function automatic logic [63:0] pat(input int k);
        case (k)
            0: return 64'h0000_0000_0000_0000;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h0000_0000_8000_0000;
            3: return 64'h0000_0000_7FFF_FFFF;
            4: return 64'h8000_0000_0000_0001;
            5: return 64'h1234_5678_9ABC_DEF0;
            6: return 64'hFEDC_BA98_7654_3210;
            default: return 64'h7FFF_FFFF_FFFF_FFFE;
        endcase
    endfunction

    // word-width extension derived arithmetically from R1..R3 and R6
    function automatic logic [63:0] model_ext(input logic [63:0] v, input bit nar, input bit fill);
        longint unsigned lo;
        lo = v % (64'd1 << 32);
        if (!nar) return v;
        if (fill && (lo >= 64'h8000_0000)) return lo + 64'hFFFF_FFFF_0000_0000;
        return lo;
    endfunction

    task automatic chk64(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        // reset state (R9)
        repeat (3) @(posedge clk);
        #1;
        chk64("R9", "arg1 reset", arg1, '0);
        chk64("R9", "arg2 reset", arg2, '0);
        chk64("R9", "rvd reset", rvd, '0);
        chk64("R9", "signs reset", {61'd0, rv1_sign, arg2_sign, res_sign}, '0);
        @(negedge clk);
        rst = 1'b0;

        // latency: result visible one edge after the inputs (R9)
        rv1 = 64'hDEAD_BEEF_0000_1111;
        @(posedge clk); #1;
        chk64("R9", "arg1 after one edge", arg1, 64'hDEAD_BEEF_0000_1111);

        for (int nar = 0; nar < 2; nar++)
        for (int sg = 0; sg < 2; sg++)
        for (int cls = 0; cls < 5; cls++) begin
            if (cls == 1 && nar == 1) continue;   // load never narrow
            for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                logic [63:0] e_a1, e_a2, e_rvd, t_reg, t_imm;
                @(negedge clk);
                narrow   = nar[0];
                sgn      = sg[0];
                is_load  = (cls == 1);
                is_store = (cls == 2);
                is_beq   = (cls == 3);
                is_blt   = (cls == 4);
                rv1      = pat(i);
                rv2      = pat(j);
                imm      = pat((i * 3 + j) % 8);
                alu_res  = pat((i + j) % 8);
                load_data = pat(7 - i) ^ 64'h0F0F_0000_0000_F0F0;
                if (cls == 0) begin
                    if (j % 2 == 1) rv2 = '0; else imm = '0;
                end
                e_a1  = model_ext(rv1, nar != 0, sg != 0);
                t_reg = (cls == 1 || cls == 2) ? 64'd0 : model_ext(rv2, nar != 0, sg != 0);
                t_imm = (cls == 3 || cls == 4) ? 64'd0 : imm;
                e_a2  = t_reg + t_imm;
                e_rvd = (cls == 1) ? load_data : model_ext(alu_res, nar != 0, 1'b1);
                @(posedge clk); #1;
                chk64("R1", "arg1 low", {32'd0, arg1[31:0]}, {32'd0, rv1[31:0]});
                if (nar == 0) chk64("R2", "arg1 full", arg1, e_a1);
                else          chk64("R3", "arg1 word", arg1, e_a1);
                chk64("R4", "arg2", arg2, e_a2);
                if (cls == 1)      chk64("R7", "rvd load", rvd, e_rvd);
                else if (nar == 0) chk64("R5", "rvd full", rvd, e_rvd);
                else               chk64("R6", "rvd word", rvd, e_rvd);
                chk64("R8", "sign bits", {61'd0, rv1_sign, arg2_sign, res_sign},
                      nar != 0 ? {61'd0, rv1[31], rv2[31], alu_res[31]} : 64'd0);
            end
        end

        // alu_res ignored during load (R7)
        @(negedge clk);
        narrow = 0; is_load = 1; is_store = 0; is_beq = 0; is_blt = 0;
        load_data = 64'h0000_0000_0000_00AB; alu_res = 64'hFFFF_FFFF_FFFF_FFFF;
        @(posedge clk); #1;
        chk64("R7", "rvd ignores alu_res", rvd, 64'h0000_0000_0000_00AB);

        // reset mid-run clears outputs (R9)
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk64("R9", "rvd after reset", rvd, '0);

        done = 1;
        finish_run();
    end
endmodule